// File: doc/BRIEF.md
# Accumulating Multiplier Coprocessor Step

This block is a short, fixed-latency arithmetic step that sits next to a processor pipeline. It keeps a single 32-bit accumulator of its own. For each operation, the processor raises a start strobe together with two 32-bit operands and a set of routing flags. The block then multiplies the first operand by one of two values. One choice is the second processor operand. The other is the block's own accumulator, picked per operation by a selection flag. The product, truncated to its low 32 bits, is written back into the accumulator.

The result port always shows the accumulator. The processor therefore reads the freshly written product in the cycle the completion strobe is high. Between operations it can read the stored value back.

A clock qualifier freezes the whole block while it is low. A synchronous reset clears it and aborts any operation in flight. Register indices and the first-source and write-back flags travel with each operation. They are part of the coprocessor calling convention, but they do not change what the block computes.

Top module: `mac_accum_unit`

## Requirements
- R1: In the cycle after a synchronous reset, `result` is zero and `done` is low; the accumulator is cleared to zero.
- R2: With `b_from_acc` low at start, `result` equals the low 32 bits of `opnd_a * opnd_b` in the cycle `done` is high, and that value stays in the accumulator.
- R3: With `b_from_acc` high at start, the accumulator value held before the operation replaces `opnd_b`, and `result` becomes the low 32 bits of `opnd_a * accumulator`.
- R4: `done` goes high exactly two enabled cycles after the cycle in which `start` is sampled high, stays high for one enabled cycle, and `result` is valid while it is high.
- R5: While `ce` is low, no register changes: `result` and `done` hold their values and a `start` request is not taken.
- R6: `result` changes only in the cycle in which `done` rises, or after a reset.
- R7: The index ports `idx_a`, `idx_b`, `idx_c` and the flags `a_from_core` and `c_to_core` have no effect on `result` or `done`. All routing inputs are held stable from start until completion.
- R8: A `start` seen in the cycle after an accepted start, while the operation is in flight, is ignored: there is only one `done` pulse, and its result belongs to the first request.
- R9: A reset during an operation cancels it: no `done` pulse follows, and `result` reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, acts regardless of `ce` |
| ce | input | 1 | Clock qualifier; all state holds while low |
| start | input | 1 | Operation request, high in the first execution cycle |
| a_from_core | input | 1 | First operand taken from processor registers (routing only) |
| b_from_acc | input | 1 | High: accumulator replaces `opnd_b` as second factor |
| c_to_core | input | 1 | Result written to processor register (routing only) |
| idx_a | input | 5 | First-source register index (routing only) |
| idx_b | input | 5 | Second-source register index (routing only) |
| idx_c | input | 5 | Destination register index (routing only) |
| opnd_a | input | 32 | First factor |
| opnd_b | input | 32 | Second factor when `b_from_acc` is low |
| result | output | 32 | Accumulator contents |
| done | output | 1 | One-cycle completion strobe |

## Verification
The bench goes after the following corner cases:

- **Accumulator self-multiply right after reset.** It must yield zero. A design that kept stale state would show a non-zero value.
- **All-ones operands.** These must wrap to 1. A design that kept the wrong product half would show something else.
- **Qualifier dropped before and during an operation.** A design that let the qualifier slip would raise `done` early or change `result` while frozen.
- **Repeated start while busy.** A design without a busy guard would run a second multiply and pulse `done` twice.
- **Reset in mid-flight.** A design with a leaking pipeline would still raise `done` after the reset.

// File: rtl/mac_accum_unit.sv
module mac_accum_unit #(
  parameter int W    = 32,
  parameter int IDXW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ce,
  input  logic            start,
  input  logic            a_from_core,
  input  logic            b_from_acc,
  input  logic            c_to_core,
  input  logic [IDXW-1:0] idx_a,
  input  logic [IDXW-1:0] idx_b,
  input  logic [IDXW-1:0] idx_c,
  input  logic [W-1:0]    opnd_a,
  input  logic [W-1:0]    opnd_b,
  output logic [W-1:0]    result,
  output logic            done
);

  logic         busy;
  logic [W-1:0] fa, fb, acc;
  logic         take;

  assign take   = start && !busy;
  assign result = acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      acc  <= '0;
      fa   <= '0;
      fb   <= '0;
    end else if (ce) begin
      done <= busy;
      busy <= take;
      if (take) begin
        fa <= opnd_a;
        fb <= b_from_acc ? acc : opnd_b;
      end
      if (busy) acc <= fa * fb;
    end
  end

  a_r4_done_one_enabled_cycle: assert property (@(posedge clk) disable iff (rst)
    (done && ce) |=> !done);

  a_r4_done_follows_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && ce) |=> done);

  a_r4_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));

  a_r5_frozen_when_disabled: assert property (@(posedge clk) disable iff (rst)
    (!ce && !rst) |=> ($stable(result) && $stable(done) && $stable(busy)));

  a_r6_result_moves_on_done: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> (done || $past(rst)));

  a_r7_routing_held: assert property (@(posedge clk) disable iff (rst)
    busy |-> $stable({a_from_core, b_from_acc, c_to_core, idx_a, idx_b, idx_c}));

  a_r8_single_flight: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

endmodule

// File: tb/tb_mac_accum_unit.sv
module tb_mac_accum_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, ce, start, a_from_core, b_from_acc, c_to_core;
  logic [4:0]  idx_a, idx_b, idx_c;
  logic [31:0] opnd_a, opnd_b, result;
  logic        done;

  int checks = 0;
  int errors = 0;
  logic [31:0] model_acc;
  bit finished = 0;

  mac_accum_unit dut (
    .clk(clk), .rst(rst), .ce(ce), .start(start),
    .a_from_core(a_from_core), .b_from_acc(b_from_acc), .c_to_core(c_to_core),
    .idx_a(idx_a), .idx_b(idx_b), .idx_c(idx_c),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] expect_prod(logic [31:0] x, logic [31:0] y,
                                              logic sel, logic [31:0] accv);
    logic [63:0] full;
    full = {32'd0, x} * {32'd0, (sel ? accv : y)};
    return full[31:0];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(logic [31:0] x, logic [31:0] y, logic sel, int stall_pre,
                    int stall_mid, int stall_done, string req);
    logic [31:0] exp;
    exp = expect_prod(x, y, sel, model_acc);
    @(negedge clk);
    opnd_a = x; opnd_b = y; b_from_acc = sel;
    a_from_core = 1'($urandom); c_to_core = 1'($urandom);
    idx_a = 5'($urandom); idx_b = 5'($urandom); idx_c = 5'($urandom);
    start = 1'b1;
    // R5: start request held off while ce is low
    for (int i = 0; i < stall_pre; i++) begin
      ce = 1'b0;
      @(negedge clk);
      chk("R5 done frozen", {31'd0, done}, 32'd0);
      chk("R5 result frozen", result, model_acc);
    end
    ce = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R4 done low mid-op", {31'd0, done}, 32'd0);
    for (int i = 0; i < stall_mid; i++) begin
      ce = 1'b0;
      @(negedge clk);
      chk("R5 no done while frozen", {31'd0, done}, 32'd0);
      chk("R6 result held mid-op", result, model_acc);
    end
    ce = 1'b1;
    @(negedge clk);
    chk({req, " done high"}, {31'd0, done}, 32'd1);
    chk({req, " result"}, result, exp);
    for (int i = 0; i < stall_done; i++) begin
      ce = 1'b0;
      @(negedge clk);
      chk("R5 done held while frozen", {31'd0, done}, 32'd1);
    end
    ce = 1'b1;
    @(negedge clk);
    chk("R4 done one cycle", {31'd0, done}, 32'd0);
    chk("R6 result stable after op", result, exp);
    model_acc = exp;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; ce = 1'b1; start = 1'b0;
    a_from_core = 0; b_from_acc = 0; c_to_core = 0;
    idx_a = 0; idx_b = 0; idx_c = 0; opnd_a = 0; opnd_b = 0;
    model_acc = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 result after reset", result, 32'd0);
    chk("R1 done after reset", {31'd0, done}, 32'd0);

    // R3: accumulator factor right after reset gives zero
    op(32'h1234_5678, 32'hFFFF_FFFF, 1'b1, 0, 0, 0, "R3");
    // R2: basic product and truncation wrap
    op(32'd7, 32'd9, 1'b0, 0, 0, 0, "R2");
    op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 0, 0, 0, "R2 wrap");
    // R3: accumulator chain
    op(32'd5, 32'hDEAD_BEEF, 1'b1, 0, 0, 0, "R3 chain");
    op(32'h0001_0000, 32'd0, 1'b1, 0, 0, 0, "R3 chain2");
    // R5: qualifier dropped before, during and at completion
    op(32'd3, 32'd11, 1'b0, 3, 2, 2, "R5 stalled");

    // R8: start held across the in-flight cycle with new data
    begin
      logic [31:0] exp8;
      exp8 = expect_prod(32'd6, 32'd7, 1'b0, model_acc);
      @(negedge clk);
      opnd_a = 32'd6; opnd_b = 32'd7; b_from_acc = 1'b0; start = 1'b1;
      @(negedge clk);
      opnd_a = 32'd100; opnd_b = 32'd100;
      chk("R8 done low in flight", {31'd0, done}, 32'd0);
      @(negedge clk);
      start = 1'b0;
      chk("R8 single result", result, exp8);
      chk("R8 done pulse", {31'd0, done}, 32'd1);
      @(negedge clk);
      chk("R8 no second done", {31'd0, done}, 32'd0);
      @(negedge clk);
      chk("R8 no second done later", {31'd0, done}, 32'd0);
      chk("R8 result kept", result, exp8);
      model_acc = exp8;
    end

    // R9: reset during an operation
    @(negedge clk);
    opnd_a = 32'd9; opnd_b = 32'd9; b_from_acc = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9 done cancelled", {31'd0, done}, 32'd0);
    chk("R9 result cleared", result, 32'd0);
    @(negedge clk);
    chk("R9 no late done", {31'd0, done}, 32'd0);
    chk("R9 result still zero", result, 32'd0);
    model_acc = 0;

    // R7: identical operands with differing routing fields give the same result
    op(32'd13, 32'd17, 1'b0, 0, 0, 0, "R7 run A");
    op(32'd13, 32'd17, 1'b0, 0, 0, 0, "R7 run B");

    // random mix of R2/R3 with occasional stalls
    for (int k = 0; k < 60; k++) begin
      op($urandom, $urandom, 1'($urandom), int'($urandom_range(0, 1)),
         int'($urandom_range(0, 2)), int'($urandom_range(0, 1)), "R2/R3 random");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule